// File: doc/BRIEF.md
# Programmable Limit Timer with Interrupt

This block is a count-up timer with three software registers reached through a small write/read port: a counter value, a limit value and a control word. While the run bit of the control word is set, the counter advances by one on every clock. Once the counter equals the limit, the next clock returns it to zero. If the interrupt enable bit is set, the same clock also sets a sticky pending flag. The interrupt output is high while both the pending flag and the enable are set.

Software arms the timer in three writes: the wanted cycle count to the limit register, zero to the counter register, then enable and run together to the control word. The pending flag cannot be written. Every control write therefore clears it, and that write serves as the acknowledge. Periodic operation comes from software writing the enable again with each acknowledge. With the limit at all ones, the enable clear and the run bit set, the block is a free-running wraparound counter.

Top module: `lim_timer`

## Requirements
- R1: After reset, the counter, limit and control registers all read zero and `irq` is low.
- R2: Register selects are 0 for the counter, 1 for the limit and 2 for the control word. A counter or limit write reads back the written value. The control word reads the enable in bit 0, the run bit in bit 1 and the pending flag in bit 3. All other control bits read zero.
- R3: While the run bit is 1 and the counter is not equal to the limit, the counter increases by one per clock. While the run bit is 0, the counter holds its value.
- R4: When the run bit is 1 and the counter equals the limit, the counter is zero on the next clock.
- R5: The clock that takes the counter from the limit to zero sets the pending flag when the enable is 1, and leaves it clear when the enable is 0.
- R6: Any write to the control word clears the pending flag, whatever value bit 3 of the write data holds.
- R7: `irq` is high exactly while the pending flag and the enable are both 1. It stays high across later clocks until a control write acknowledges it.
- R8: With the limit at all ones, the counter goes from all ones to zero and keeps counting up.
- R9: A counter write takes effect in the clock it is made, in place of that clock's increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 counter, 1 limit, 2 control |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The counting path is run from a table of cases that differ in limit, start value, control bits and wait length. Waits that stop short of the limit check the per-clock step. Waits that run past it show whether the return to zero happens one clock after equality. A case with a zero limit makes the counter wrap on every clock. A case with the run bit clear and a case with the enable clear separate holding from counting and a wrap that raises the pending flag from one that does not. Directed tests then cover an acknowledge write with bit 3 set, an interrupt that persists over many clocks, a counter write made while running, and the all-ones wrap.

// File: rtl/lim_timer_pkg.sv
package lim_timer_pkg;
   localparam int SEL_W = 2;
   typedef enum logic [SEL_W-1:0] {
      SEL_COUNT = 2'd0,
      SEL_LIMIT = 2'd1,
      SEL_CTRL  = 2'd2,
      SEL_NONE  = 2'd3
   } sel_e;
   localparam int BIT_IE   = 0;
   localparam int BIT_RUN  = 1;
   localparam int BIT_PEND = 3;
   localparam int CTRL_USED = 4;
endpackage

// File: rtl/lim_timer_count.sv
module lim_timer_count #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cnt_wr,
   input  logic         lim_wr,
   input  logic [W-1:0] wdata,
   input  logic         run,
   output logic [W-1:0] count_q,
   output logic [W-1:0] limit_q,
   output logic         hit
);
   logic at_limit;
   assign at_limit = (count_q == limit_q);
   assign hit      = run && at_limit && !cnt_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (cnt_wr) begin
         count_q <= wdata;
      end else if (run) begin
         if (at_limit) count_q <= '0;
         else          count_q <= count_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      limit_q <= '0;
      else if (lim_wr) limit_q <= wdata;
   end
endmodule

// File: rtl/lim_timer_ctrl.sv
module lim_timer_ctrl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctrl_wr,
   input  logic [1:0] wbits,
   input  logic       hit,
   output logic       ie_q,
   output logic       run_q,
   output logic       pend_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q  <= 1'b0;
         run_q <= 1'b0;
      end else if (ctrl_wr) begin
         ie_q  <= wbits[0];
         run_q <= wbits[1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_q <= 1'b0;
      else if (ctrl_wr)    pend_q <= 1'b0;
      else if (hit && ie_q) pend_q <= 1'b1;
   end
endmodule

// File: rtl/lim_timer.sv
module lim_timer
   import lim_timer_pkg::*;
#(
   parameter int W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] reg_sel,
   input  logic [W-1:0]     wr_data,
   output logic [W-1:0]     rd_data,
   output logic             irq
);
   localparam int PAD_W = W - CTRL_USED;

   generate
      if (W < CTRL_USED) begin : g_bad_width
         $error("lim_timer: W must be at least CTRL_USED");
      end
   endgenerate

   logic         cnt_wr, lim_wr, ctrl_wr, hit;
   logic         ie_q, run_q, pend_q;
   logic [W-1:0] count_q, limit_q;
   logic [W-1:0] ctrl_word;

   assign cnt_wr  = wr_en && (reg_sel == SEL_COUNT);
   assign lim_wr  = wr_en && (reg_sel == SEL_LIMIT);
   assign ctrl_wr = wr_en && (reg_sel == SEL_CTRL);

   lim_timer_count #(.W(W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_wr  (cnt_wr),
      .lim_wr  (lim_wr),
      .wdata   (wr_data),
      .run     (run_q),
      .count_q (count_q),
      .limit_q (limit_q),
      .hit     (hit)
   );

   lim_timer_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_wr (ctrl_wr),
      .wbits   ({wr_data[BIT_RUN], wr_data[BIT_IE]}),
      .hit     (hit),
      .ie_q    (ie_q),
      .run_q   (run_q),
      .pend_q  (pend_q)
   );

   assign ctrl_word = {{PAD_W{1'b0}}, pend_q, 1'b0, run_q, ie_q};

   always_comb begin
      unique case (reg_sel)
         SEL_COUNT: rd_data = count_q;
         SEL_LIMIT: rd_data = limit_q;
         SEL_CTRL:  rd_data = ctrl_word;
         default:   rd_data = '0;
      endcase
   end

   assign irq = pend_q && ie_q;
endmodule

// File: rtl/lim_timer_chk.sv
module lim_timer_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         wr_en,
   input logic [1:0]   reg_sel,
   input logic [W-1:0] rd_data,
   input logic         irq,
   input logic [W-1:0] count_q,
   input logic [W-1:0] limit_q,
   input logic         ie_q,
   input logic         run_q,
   input logic         pend_q
);
   logic wc, wk;
   assign wc = wr_en && (reg_sel == 2'd0);
   assign wk = wr_en && (reg_sel == 2'd2);

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wc && !run_q) |=> (count_q == $past(count_q)));
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wc && run_q && count_q != limit_q) |=> (count_q == $past(count_q) + 1'b1));
   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wc && run_q && count_q == limit_q) |=> (count_q == '0));
   p_pend_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wc && !wk && run_q && ie_q && count_q == limit_q) |=> pend_q);
   p_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wk |=> !pend_q);
   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !wk) |=> irq);
   p_ctrl_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 2'd2) |-> (rd_data[W-1:4] == '0 && rd_data[2] == 1'b0));
endmodule

bind lim_timer lim_timer_chk #(.W(W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .reg_sel (reg_sel),
   .rd_data (rd_data),
   .irq     (irq),
   .count_q (count_q),
   .limit_q (limit_q),
   .ie_q    (ie_q),
   .run_q   (run_q),
   .pend_q  (pend_q)
);

// File: tb/tb_lim_timer.sv
module tb_lim_timer;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 6;

   localparam logic [31:0] V_LIM  [NV] = '{32'd5, 32'd5, 32'd0, 32'd10, 32'd9, 32'd3};
   localparam logic [31:0] V_CNT  [NV] = '{32'd0, 32'd0, 32'd0, 32'd4,  32'd2, 32'd0};
   localparam logic [1:0]  V_CTRL [NV] = '{2'd3,  2'd3,  2'd3,  2'd1,   2'd2,  2'd2};
   localparam int          V_WAIT [NV] = '{3, 7, 2, 5, 12, 4};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        irq;
   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lim_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
                  .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [31:0] d);
      reg_sel = s; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [31:0] d);
      reg_sel = s; #1; d = rd_data;
   endtask

   task automatic arm(input logic [31:0] l, input logic [31:0] c, input logic [1:0] ct);
      wr(2'd2, 32'd0);
      wr(2'd1, l);
      wr(2'd0, c);
      wr(2'd2, {30'd0, ct});
   endtask

   initial begin
      #(CLK_PERIOD*100000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      @(negedge clk); @(negedge clk);
      rd(2'd0, v); chk("R1 count", v, 0);
      rd(2'd1, v); chk("R1 limit", v, 0);
      rd(2'd2, v); chk("R1 ctrl", v, 0);
      chk("R1 irq", {31'd0, irq}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 readback
      wr(2'd1, 32'hA5A5_1234); rd(2'd1, v); chk("R2 limit", v, 32'hA5A5_1234);
      wr(2'd0, 32'h0000_0777); rd(2'd0, v); chk("R2 count", v, 32'h0000_0777);
      wr(2'd2, 32'hFFFF_FFFC); rd(2'd2, v); chk("R2 ctrl mask", v, 0);
      rd(2'd0, v); chk("R2 count held", v, 32'h0000_0777);

      // table of cases, expectation from a model of R3 R4 R5 R7
      for (int i = 0; i < NV; i++) begin
         logic [31:0] mc;
         logic mp;
         arm(V_LIM[i], V_CNT[i], V_CTRL[i]);
         mc = V_CNT[i]; mp = 1'b0;
         for (int k = 0; k < V_WAIT[i]; k++) begin
            @(negedge clk);
            if (V_CTRL[i][1]) begin
               if (mc == V_LIM[i]) begin mc = 0; if (V_CTRL[i][0]) mp = 1'b1; end
               else mc = mc + 1;
            end
         end
         rd(2'd0, v); chk("R3 R4 table count", v, mc);
         rd(2'd2, v); chk("R5 table pend", {31'd0, v[3]}, {31'd0, mp});
         chk("R7 table irq", {31'd0, irq}, {31'd0, mp & V_CTRL[i][0]});
      end

      // R7 level persists, R6 ack with bit3 set
      arm(32'd2, 32'd0, 2'd3);
      repeat (3) @(negedge clk);
      chk("R7 irq raised", {31'd0, irq}, 1);
      repeat (20) @(negedge clk);
      chk("R7 irq persists", {31'd0, irq}, 1);
      wr(2'd2, 32'h0000_000A);
      rd(2'd2, v); chk("R6 ack pend clear", v, 32'h2);
      chk("R6 irq low", {31'd0, irq}, 0);

      // R9 count write while running
      arm(32'd1000, 32'd0, 2'd2);
      repeat (5) @(negedge clk);
      wr(2'd0, 32'd100);
      rd(2'd0, v); chk("R9 write wins", v, 100);
      @(negedge clk);
      rd(2'd0, v); chk("R9 next step", v, 101);

      // R8 all-ones wrap
      arm(32'hFFFF_FFFF, 32'hFFFF_FFFE, 2'd2);
      @(negedge clk);
      rd(2'd0, v); chk("R8 at max", v, 32'hFFFF_FFFF);
      @(negedge clk);
      rd(2'd0, v); chk("R8 wrapped", v, 0);
      @(negedge clk);
      rd(2'd0, v); chk("R8 continues", v, 1);
      rd(2'd2, v); chk("R8 no pend", {31'd0, v[3]}, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule